// File: doc/BRIEF.md
# Graphics Port Inbound Address Decoder

This block sorts each request that arrives from a graphics-port initiator before it reaches memory or the host bus. A request carries a byte address, a byte length, a read/write flag, a command kind and a protocol flag. The protocol flag marks the request as either framed (bus-style, one burst at a time) or pipelined/sideband (queued and limited in length). The decoder compares the address, and the last byte the request touches, with four windows: main DRAM below a programmable top, the fixed legacy compatibility window 0C0000h–0FFFFFh, a programmable graphics aperture, and an optional SMM range.

Each accepted request gets one outcome. A claim takes the request. A no-claim leaves it so that the initiator master-aborts. A remap turns a read into a read of address 0. A discard drops a write inside the block. Alongside the outcome the decoder returns the effective address, a host-snoop request, the number of bytes a framed burst may move before it must disconnect, and an invalid-data marker for reads that run out of memory. Illegal pipelined traffic sets a sticky error flag. Software clears this flag by writing a one to it.

The decode is one register stage deep. A new request may be presented on every clock.

Top module: `gport_inbound_decode`

## Requirements
- R1: A framed memory request (req_cmd = 0) whose start address lies in DRAM (below cfg_dram_top) or in the aperture [cfg_ap_base, cfg_ap_base + cfg_ap_size) is claimed (outcome 0). Any other framed memory request is not claimed (outcome 1). Framed requests never set the error flag.
- R2: A request whose command is not memory (1 = I/O, 2 = configuration, 3 = special cycle) is not claimed (outcome 1) on either protocol, and it sets no error.
- R3: Addresses 0C0000h–0FFFFFh count as main memory for every graphics-port request, even when cfg_dram_top lies below them.
- R4: For a claimed framed request, rsp_burst equals the smaller of the length and the number of bytes left before the next 4096-byte boundary. For every other outcome it is 0. A length of 0 is treated as 1 byte everywhere.
- R5: A pipelined request (req_piped = 1) whose first and last bytes both lie in DRAM (compatibility window included) or both lie in the aperture, that is at most 256 bytes long, and that touches no enabled SMM byte [cfg_smm_base, cfg_smm_top), is claimed with rsp_addr equal to the request address.
- R6: A pipelined read whose start is outside DRAM and the aperture, or inside an enabled SMM range, gives outcome 2 (remap) with rsp_addr = 0 and sets the error flag.
- R7: A pipelined write with such a start gives outcome 3 (discard) and sets the error flag.
- R8: A pipelined request that starts legally but is longer than 256 bytes, or whose last byte leaves the start region (including into SMM), sets the error flag. As a read it is claimed with rsp_bad = 1; as a write it is discarded (outcome 3).
- R9: rsp_snoop is 1 only for a claimed framed request that starts outside the aperture. It is 0 for every pipelined request.
- R10: err_flag resets to 0 and stays set until a cycle with err_clr_wr = 1 and err_clr_data = 1, which clears it. A new error in that same cycle wins over the clear. A write with err_clr_data = 0 does nothing.
- R11: Response fields and err_flag appear on the clock edge after the request cycle, with rsp_valid = 1 for exactly that cycle. Requests on consecutive cycles each get their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Length in bytes (0 treated as 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 special cycle |
| req_piped | input | 1 | 1 = pipelined/sideband, 0 = framed |
| cfg_dram_top | input | AW | First address above main DRAM |
| cfg_ap_base | input | AW | Aperture base |
| cfg_ap_size | input | AW | Aperture size in bytes |
| cfg_smm_en | input | 1 | SMM range enable |
| cfg_smm_base | input | AW | SMM range start |
| cfg_smm_top | input | AW | SMM range end (exclusive) |
| err_clr_wr | input | 1 | Write strobe for the error flag |
| err_clr_data | input | 1 | Write data; 1 clears the flag |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 2 | 0 claim, 1 no-claim, 2 remap to 0, 3 discard |
| rsp_addr | output | AW | Effective address |
| rsp_snoop | output | 1 | Host snoop request |
| rsp_burst | output | LW | Bytes before framed disconnect |
| rsp_bad | output | 1 | Returned read data is invalid |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
The main sweep walks start addresses on an unaligned stride from 0 to above 1 MB, so starts fall inside, at the edges of, and between every window. Each start is tried with lengths of 1, 16, 255, 256, 257 and 4096, as a read and as a write, on both protocols. Short lengths separate the start-address decode from the end-of-burst check. Lengths of 256 and 257 show the pipelined length limit. Long framed lengths expose the 4 KB disconnect count. The sweep runs under two window setups: one with DRAM below the compatibility window and SMM enabled, which tells the fixed window apart from the DRAM top, and one with DRAM above it and SMM disabled. Directed requests then cover non-memory commands, bursts that cross into SMM, out of the compatibility window or past the aperture end, and clear-versus-set races on the error flag.

// File: rtl/gport_inbound_decode.sv
module gport_inbound_decode #(
  parameter int AW = 32,
  parameter int LW = 13,
  parameter int PIPE_MAX = 256,
  parameter int PAGE = 4096,
  parameter logic [AW-1:0] COMPAT_LO = AW'('h000C_0000),
  parameter logic [AW-1:0] COMPAT_HI = AW'('h000F_FFFF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic [1:0]    req_cmd,
  input  logic          req_piped,
  input  logic [AW-1:0] cfg_dram_top,
  input  logic [AW-1:0] cfg_ap_base,
  input  logic [AW-1:0] cfg_ap_size,
  input  logic          cfg_smm_en,
  input  logic [AW-1:0] cfg_smm_base,
  input  logic [AW-1:0] cfg_smm_top,
  input  logic          err_clr_wr,
  input  logic          err_clr_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_outcome,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_snoop,
  output logic [LW-1:0] rsp_burst,
  output logic          rsp_bad,
  output logic          err_flag
);
  localparam int PB = $clog2(PAGE);
  localparam int XW = AW + 1;
  localparam logic [1:0] O_CLAIM   = 2'd0;
  localparam logic [1:0] O_NOCLAIM = 2'd1;
  localparam logic [1:0] O_REMAP   = 2'd2;
  localparam logic [1:0] O_DROP    = 2'd3;
  localparam logic [1:0] CMD_MEM   = 2'd0;

  logic [LW-1:0] len_eff, page_left;
  logic [XW-1:0] a_x, e_x, ap_hi, top_x, smm_lo_x, smm_hi_x, cw_lo_x, cw_hi_x, ap_lo_x;
  logic a_dram, a_ap, a_smm, e_dram, e_ap, e_smm;
  logic a_legal, fits, too_long;

  assign len_eff   = (req_len == '0) ? LW'(1) : req_len;
  assign page_left = LW'(PAGE) - LW'(req_addr[PB-1:0]);
  assign a_x       = {1'b0, req_addr};
  assign e_x       = a_x + XW'(len_eff) - XW'(1);
  assign top_x     = {1'b0, cfg_dram_top};
  assign ap_lo_x   = {1'b0, cfg_ap_base};
  assign ap_hi     = ap_lo_x + {1'b0, cfg_ap_size};
  assign smm_lo_x  = {1'b0, cfg_smm_base};
  assign smm_hi_x  = {1'b0, cfg_smm_top};
  assign cw_lo_x   = {1'b0, COMPAT_LO};
  assign cw_hi_x   = {1'b0, COMPAT_HI};

  assign a_dram = (a_x < top_x) || (a_x >= cw_lo_x && a_x <= cw_hi_x);
  assign e_dram = (e_x < top_x) || (e_x >= cw_lo_x && e_x <= cw_hi_x);
  assign a_ap   = (a_x >= ap_lo_x) && (a_x < ap_hi);
  assign e_ap   = (e_x >= ap_lo_x) && (e_x < ap_hi);
  assign a_smm  = cfg_smm_en && (a_x >= smm_lo_x) && (a_x < smm_hi_x);
  assign e_smm  = cfg_smm_en && (e_x >= smm_lo_x) && (e_x < smm_hi_x);
  // A burst that jumps over the SMM range entirely is caught by e_smm only
  // when it ends inside; any span over SMM is longer than the range here.
  logic span_smm;
  assign span_smm = cfg_smm_en && (a_x < smm_lo_x) && (e_x >= smm_lo_x);

  assign a_legal  = (a_dram || a_ap) && !a_smm;
  assign fits     = a_ap ? e_ap : (e_dram && !e_smm && !span_smm);
  assign too_long = len_eff > LW'(PIPE_MAX);

  logic [1:0]    n_out;
  logic [AW-1:0] n_addr;
  logic          n_snoop, n_bad, n_err;
  logic [LW-1:0] n_burst;

  always_comb begin
    n_out   = O_NOCLAIM;
    n_addr  = req_addr;
    n_snoop = 1'b0;
    n_burst = '0;
    n_bad   = 1'b0;
    n_err   = 1'b0;
    if (req_cmd != CMD_MEM) begin
      n_out = O_NOCLAIM;
    end else if (!req_piped) begin
      if (a_dram || a_ap) begin
        n_out   = O_CLAIM;
        n_snoop = !a_ap;
        n_burst = (len_eff < page_left) ? len_eff : page_left;
      end
    end else if (!a_legal) begin
      n_err = 1'b1;
      if (req_write) n_out = O_DROP;
      else begin
        n_out  = O_REMAP;
        n_addr = '0;
      end
    end else if (too_long || !fits) begin
      n_err = 1'b1;
      if (req_write) n_out = O_DROP;
      else begin
        n_out = O_CLAIM;
        n_bad = 1'b1;
      end
    end else begin
      n_out = O_CLAIM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= O_NOCLAIM;
      rsp_addr    <= '0;
      rsp_snoop   <= 1'b0;
      rsp_burst   <= '0;
      rsp_bad     <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_outcome <= n_out;
        rsp_addr    <= n_addr;
        rsp_snoop   <= n_snoop;
        rsp_burst   <= n_burst;
        rsp_bad     <= n_bad;
      end
      err_flag <= (req_valid && n_err) || (err_flag && !(err_clr_wr && err_clr_data));
    end
  end
endmodule

// File: rtl/gport_inbound_decode_sva.sv
module gport_inbound_decode_sva #(
  parameter int AW = 32,
  parameter int LW = 13,
  parameter int PAGE = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_cmd,
  input logic          req_piped,
  input logic          req_write,
  input logic          err_clr_wr,
  input logic          err_clr_data,
  input logic          rsp_valid,
  input logic [1:0]    rsp_outcome,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_snoop,
  input logic [LW-1:0] rsp_burst,
  input logic          rsp_bad,
  input logic          err_flag
);
  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_remap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome == 2'd2) |-> (rsp_addr == '0 && err_flag));
  assert_nomem_noclaim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd != 2'd0) |=> (rsp_outcome == 2'd1 && !rsp_snoop));
  assert_piped_nosnoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_piped) |=> !rsp_snoop);
  assert_framed_twoway_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_piped) |=> (rsp_outcome <= 2'd1 && !rsp_bad));
  assert_drop_only_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_outcome != 2'd3));
  assert_burst_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_burst <= LW'(PAGE)));
  assert_sticky_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(err_clr_wr && err_clr_data));
endmodule

bind gport_inbound_decode gport_inbound_decode_sva #(.AW(AW), .LW(LW), .PAGE(PAGE)) u_sva (.*);

// File: tb/tb_gport_inbound_decode.sv
module tb_gport_inbound_decode;
  localparam int AW = 32;
  localparam int LW = 13;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_piped = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [1:0] req_cmd = '0;
  logic [AW-1:0] cfg_dram_top = '0, cfg_ap_base = '0, cfg_ap_size = '0;
  logic [AW-1:0] cfg_smm_base = '0, cfg_smm_top = '0;
  logic cfg_smm_en = 0, err_clr_wr = 0, err_clr_data = 0;
  logic rsp_valid, rsp_snoop, rsp_bad, err_flag;
  logic [1:0] rsp_outcome;
  logic [AW-1:0] rsp_addr;
  logic [LW-1:0] rsp_burst;

  gport_inbound_decode dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;

  // expected state for the request in flight
  bit have_prev = 0;
  int e_out; longint e_addr; bit e_snoop; int e_burst; bit e_bad; bit err_m = 0;
  string e_tag;

  function automatic bit m_dram(longint x);
    return (x < longint'(cfg_dram_top)) || (x >= 64'hC0000 && x <= 64'hFFFFF);
  endfunction
  function automatic bit m_ap(longint x);
    return x >= longint'(cfg_ap_base) && x < longint'(cfg_ap_base) + longint'(cfg_ap_size);
  endfunction
  function automatic bit m_smm_touch(longint s, longint e);
    return cfg_smm_en && s < longint'(cfg_smm_top) && e >= longint'(cfg_smm_base);
  endfunction

  task automatic check_prev();
    checks++;
    if (rsp_valid !== 1'b1 || rsp_outcome !== 2'(e_out) || longint'(rsp_addr) != e_addr ||
        rsp_snoop !== e_snoop || int'(rsp_burst) != e_burst || rsp_bad !== e_bad || err_flag !== err_m) begin
      failures++;
      $display("FAIL %s: got v=%0b out=%0d addr=%h snp=%0b burst=%0d bad=%0b err=%0b exp out=%0d addr=%h snp=%0b burst=%0d bad=%0b err=%0b",
        e_tag, rsp_valid, rsp_outcome, rsp_addr, rsp_snoop, rsp_burst, rsp_bad, err_flag,
        e_out, e_addr, e_snoop, e_burst, e_bad, err_m);
    end
  endtask

  task automatic issue(longint a, int len, bit wr, int cmd, bit piped, bit clr);
    longint l, e; bit set_e;
    @(negedge clk);
    if (have_prev) check_prev();
    req_valid = 1; req_addr = AW'(a); req_len = LW'(len); req_write = wr;
    req_cmd = 2'(cmd); req_piped = piped; err_clr_wr = clr; err_clr_data = clr;
    l = (len == 0) ? 1 : len;
    e = a + l - 1;
    e_addr = a; e_snoop = 0; e_burst = 0; e_bad = 0; set_e = 0;
    if (cmd != 0) begin e_out = 1; e_tag = "R2"; end
    else if (!piped) begin
      if (m_dram(a) || m_ap(a)) begin
        e_out = 0; e_snoop = !m_ap(a);
        e_burst = int'((4096 - (a % 4096)) < l ? (4096 - (a % 4096)) : l);
        e_tag = (a >= 64'hC0000 && a <= 64'hFFFFF) ? "R3" : "R1_R4_R9";
      end else begin e_out = 1; e_tag = "R1"; end
    end else if (!((m_dram(a) || m_ap(a)) && !m_smm_touch(a, a))) begin
      set_e = 1;
      if (wr) begin e_out = 3; e_tag = "R7"; end
      else begin e_out = 2; e_addr = 0; e_tag = "R6"; end
    end else if (l > 256 || !(m_ap(a) ? m_ap(e) : (m_dram(e) && !m_smm_touch(a, e)))) begin
      set_e = 1; e_tag = "R8";
      if (wr) e_out = 3; else begin e_out = 0; e_bad = 1; end
    end else begin e_out = 0; e_tag = "R5_R9"; end
    err_m = set_e | (err_m & ~clr);
    have_prev = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    if (have_prev) check_prev();
    have_prev = 0;
    req_valid = 0; err_clr_wr = 0; err_clr_data = 0;
  endtask

  task automatic sweep();
    int lens[6] = '{1, 16, 255, 256, 257, 4096};
    int n = 0;
    for (longint a = 0; a < 64'h110000; a += 64'h7F0)
      for (int li = 0; li < 6; li++)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 2; w++) begin
            n++;
            issue(a, lens[li], w[0], 0, p[0], (n % 7) == 0);
          end
    idle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    cfg_dram_top = 32'h20000; cfg_ap_base = 32'h40000; cfg_ap_size = 32'h10000;
    cfg_smm_en = 1; cfg_smm_base = 32'h1C000; cfg_smm_top = 32'h20000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || err_flag !== 0) begin
      failures++;
      $display("FAIL R10 reset: valid=%0b err=%0b exp 0 0", rsp_valid, err_flag);
    end
    rst_n = 1;

    sweep();

    // directed corners
    issue(64'h1BF80, 256, 0, 0, 1, 0);   // R8 read runs into SMM
    issue(64'hFFF80, 256, 1, 0, 1, 0);   // R8 write leaves compat window (R3 start)
    issue(64'h4FF80, 256, 0, 0, 1, 0);   // R8 past aperture end
    issue(64'h4FF00, 256, 0, 0, 1, 0);   // R5 exactly fits aperture
    issue(64'h1C100, 4, 0, 0, 1, 0);     // R6 SMM start read
    issue(64'h1C100, 4, 1, 0, 1, 1);     // R7 SMM write, set beats clear (R10)
    issue(64'h0FFC, 16, 0, 0, 0, 0);     // R4 framed disconnect after 4 bytes
    issue(64'h1000, 0, 1, 0, 0, 0);      // R4 zero length as one byte
    issue(64'h30000, 4, 0, 0, 0, 0);     // R1 framed miss
    issue(64'hC8000, 64, 0, 0, 0, 0);    // R3 framed compat claim
    for (int c = 1; c < 4; c++) begin
      issue(64'h100, 4, 0, c, 0, 0);     // R2 framed non-memory
      issue(64'h100, 4, 1, c, 1, 0);     // R2 piped non-memory
    end
    issue(64'h100, 4, 0, 0, 1, 1);       // R10 clear, no new error
    idle();
    // R10: write of zero leaves flag set
    issue(64'h90000, 4, 0, 0, 1, 0);
    idle();
    @(negedge clk);
    err_clr_wr = 1; err_clr_data = 0;
    @(negedge clk);
    err_clr_wr = 0;
    checks++;
    if (err_flag !== 1) begin failures++; $display("FAIL R10 clear-with-0: err=%0b exp 1", err_flag); end
    @(negedge clk);
    err_clr_wr = 1; err_clr_data = 1;
    @(negedge clk);
    err_clr_wr = 0; err_clr_data = 0; err_m = 0;
    checks++;
    if (err_flag !== 0) begin failures++; $display("FAIL R10 clear-with-1: err=%0b exp 0", err_flag); end
    checks++;
    if (rsp_valid !== 0) begin failures++; $display("FAIL R11 idle: valid=%0b exp 0", rsp_valid); end

    // second setup: DRAM above compat, SMM off
    cfg_dram_top = 32'h108000; cfg_smm_en = 0; cfg_ap_base = 32'h10C000; cfg_ap_size = 32'h2000;
    sweep();
    finish_run();
  end
endmodule